// File: doc/BRIEF.md
# Configuration Window Base Decoder

This block holds one 64-bit control register that places a memory-mapped configuration window in the CPU address space, and it matches CPU addresses against that window. A 2-bit size code picks a window of 256 MiB, 128 MiB or 64 MiB. The size also sets how many low base bits take part in the decode, so the base is always aligned to the window size. For an address inside an enabled, legal window, the block raises a hit and splits the offset into bus, device, function and register fields.

The register is written through a byte-enabled port and can be read back. The decode follows the register on the clock edge that updates it. The address lookup is combinational on the current decode. It carries no handshake, because each address gets its answer in the same cycle, so there is no stream to stall and no back-pressure. A reserved size code raises an error flag and blocks every hit until a later write restores a legal code.

Top module: `cfg_window_decoder`

## Requirements
- R1: A synchronous reset loads the register with 64'h0000_0000_B000_0001 and clears the error flag. That value is enabled, 256 MiB, with base 0xB000_0000.
- R2: Register bit 0 enables the window. While it is 0, `win_valid` and `lk_hit` stay low for every address.
- R3: Register bits 2:1 hold the size code: 00 gives 256 MiB (`win_log2` = 28), 01 gives 128 MiB (27) and 10 gives 64 MiB (26).
- R4: A write updates only the bytes whose `wr_be` bit is set (lane n covers bits 8n+7:8n). The decode reflects the new contents from the cycle after the write edge, even when only some lanes are written. With `wr_en` low, or with all enables clear, the register is left unchanged.
- R5: The window base is register bits 35 down to `win_log2`. All register bits below `win_log2`, and all above 35, are ignored for the base.
- R6: Size code 11 sets `len_err` after the write edge, drops `win_valid`, reports `win_log2` = 0 and base 0, and blocks hits. The flag remains set through writes that leave lane 0 untouched, and clears on the first write that puts a legal code into bits 2:1.
- R7: `lk_hit` is high when the window is valid and `lk_addr` equals the base in every bit from `win_log2` up to `ADDR_W`-1. Any set address bit above 35 therefore misses.
- R8: On a hit, with offset = the `lk_addr` bits below `win_log2`, the outputs are bus = offset[27:20], device = offset[19:15], function = offset[14:12] and register = offset[11:0]. Bus bits at or above the window size read 0. On a miss all four fields are 0.
- R9: A lookup made in the same cycle as a write uses the decode from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_be | input | 8 | Byte-lane enables for the write |
| wr_data | input | 64 | Write data |
| rd_data | output | 64 | Current register contents |
| win_valid | output | 1 | Window enabled and size code legal |
| win_base | output | ADDR_W | Decoded, size-aligned window base |
| win_log2 | output | 5 | log2 of the window size in bytes, 0 when the code is reserved |
| len_err | output | 1 | Sticky reserved-size error |
| lk_addr | input | ADDR_W | CPU address to match |
| lk_hit | output | 1 | Address falls inside the window |
| lk_bus | output | 8 | Bus number of the hit |
| lk_dev | output | 5 | Device number of the hit |
| lk_fn | output | 3 | Function number of the hit |
| lk_reg | output | 12 | Register offset of the hit |

## Verification
A register write and an address lookup can fall in the same cycle. The lookup must be answered from the old decode, and only lookups after the write edge may see the new one. The bench holds an address that lies inside the new window but outside the old one, drives the write with that address already present, and checks that `lk_hit` stays low before the edge. It then checks that `lk_hit` is high with the expected fields one cycle later. A reserved-code write that shares its cycle with a lookup inside the old window is judged the same way: the lookup hits before the edge, and after the edge the hit is gone and `len_err` is set.

// File: rtl/cfg_window_pkg.sv
package cfg_window_pkg;
  typedef enum logic [1:0] {
    SZ_256M = 2'b00,
    SZ_128M = 2'b01,
    SZ_64M  = 2'b10,
    SZ_RSVD = 2'b11
  } win_size_e;

  localparam int REG_W    = 64;
  localparam int LANES    = REG_W / 8;
  localparam int EN_BIT   = 0;
  localparam int SZ_LSB   = 1;
  localparam int BASE_TOP = 35;
  localparam int OFF_W    = 28;
  localparam int LOG2_W   = 5;

  typedef struct packed {
    logic [7:0]  bus;
    logic [4:0]  dev;
    logic [2:0]  fn;
    logic [11:0] rg;
  } bdf_t;

  function automatic logic [LOG2_W-1:0] size_log2(input win_size_e code);
    case (code)
      SZ_256M: size_log2 = LOG2_W'(28);
      SZ_128M: size_log2 = LOG2_W'(27);
      SZ_64M:  size_log2 = LOG2_W'(26);
      default: size_log2 = '0;
    endcase
  endfunction
endpackage

// File: rtl/cfg_window_reg.sv
module cfg_window_reg
  import cfg_window_pkg::*;
#(
  parameter logic [REG_W-1:0] RESET_VAL = 64'h0000_0000_B000_0001
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [LANES-1:0] wr_be,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] cfg_q,
  output logic             err_q
);
  logic [7:0] lane_q [LANES];

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst)
        lane_q[b] <= RESET_VAL[b*8 +: 8];
      else if (wr_en && wr_be[b])
        lane_q[b] <= wr_data[b*8 +: 8];
    end
    assign cfg_q[b*8 +: 8] = lane_q[b];
  end

  // Sticky reserved-size flag; only a write to lane 0 can change it.
  always_ff @(posedge clk) begin
    if (rst)
      err_q <= (RESET_VAL[SZ_LSB +: 2] == SZ_RSVD);
    else if (wr_en && wr_be[0])
      err_q <= (wr_data[SZ_LSB +: 2] == SZ_RSVD);
  end

  // R4: no write strobe, no change
  p_hold_no_write_r4: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(cfg_q));

  // R6: flag agrees with the stored size code
  p_err_matches_code_r6: assert property (@(posedge clk) disable iff (rst)
    err_q == (cfg_q[SZ_LSB +: 2] == SZ_RSVD));
endmodule

// File: rtl/cfg_window_decode.sv
module cfg_window_decode
  import cfg_window_pkg::*;
#(
  parameter int ADDR_W = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_W-1:0]  cfg_q,
  input  logic              err_q,
  output logic              win_valid,
  output logic [ADDR_W-1:0] win_base,
  output logic [ADDR_W-1:0] win_low_mask,
  output logic [LOG2_W-1:0] win_log2
);
  localparam logic [ADDR_W-1:0] TOP_MASK = (ADDR_W'(1) << (BASE_TOP + 1)) - ADDR_W'(1);

  win_size_e code;

  always_comb begin
    code         = win_size_e'(cfg_q[SZ_LSB +: 2]);
    win_log2     = size_log2(code);
    win_low_mask = (ADDR_W'(1) << win_log2) - ADDR_W'(1);
    win_valid    = cfg_q[EN_BIT] && !err_q;
    if (code == SZ_RSVD)
      win_base = '0;
    else
      win_base = cfg_q[ADDR_W-1:0] & TOP_MASK & ~win_low_mask;
  end

  // R3: a valid window has one of the three legal sizes
  p_legal_size_r3: assert property (@(posedge clk) disable iff (rst)
    win_valid |-> (win_log2 == 5'd26 || win_log2 == 5'd27 || win_log2 == 5'd28));

  // R6: an error never coexists with a valid window
  p_err_blocks_valid_r6: assert property (@(posedge clk) disable iff (rst)
    err_q |-> !win_valid);
endmodule

// File: rtl/cfg_window_match.sv
module cfg_window_match
  import cfg_window_pkg::*;
#(
  parameter int ADDR_W = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              win_valid,
  input  logic [ADDR_W-1:0] win_base,
  input  logic [ADDR_W-1:0] win_low_mask,
  input  logic [LOG2_W-1:0] win_log2,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_hit,
  output bdf_t              lk_bdf
);
  logic [OFF_W-1:0] offset;

  always_comb begin
    lk_hit = win_valid && (((lk_addr ^ win_base) & ~win_low_mask) == '0);
    offset = lk_addr[OFF_W-1:0] & win_low_mask[OFF_W-1:0];
    if (lk_hit)
      lk_bdf = {offset[27:20], offset[19:15], offset[14:12], offset[11:0]};
    else
      lk_bdf = '0;
  end

  // R2: disabled or invalid window never hits
  p_no_hit_invalid_r2: assert property (@(posedge clk) disable iff (rst)
    !win_valid |-> !lk_hit);

  // R8: bus bits beyond a 64 MiB window stay zero
  p_bus_bound_r8: assert property (@(posedge clk) disable iff (rst)
    (lk_hit && win_log2 == 5'd26) |-> (lk_bdf.bus[7:6] == 2'b00));

  // R8: a miss reports empty fields
  p_miss_zero_r8: assert property (@(posedge clk) disable iff (rst)
    !lk_hit |-> (lk_bdf == '0));
endmodule

// File: rtl/cfg_window_decoder.sv
module cfg_window_decoder
  import cfg_window_pkg::*;
#(
  parameter int ADDR_W = 40,
  parameter logic [63:0] RESET_VAL = 64'h0000_0000_B000_0001
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [7:0]        wr_be,
  input  logic [63:0]       wr_data,
  output logic [63:0]       rd_data,
  output logic              win_valid,
  output logic [ADDR_W-1:0] win_base,
  output logic [4:0]        win_log2,
  output logic              len_err,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_hit,
  output logic [7:0]        lk_bus,
  output logic [4:0]        lk_dev,
  output logic [2:0]        lk_fn,
  output logic [11:0]       lk_reg
);
  logic [REG_W-1:0]  cfg_q;
  logic              err_q;
  logic [ADDR_W-1:0] low_mask;
  bdf_t              bdf;

  cfg_window_reg #(.RESET_VAL(RESET_VAL)) u_reg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_be(wr_be),
    .wr_data(wr_data), .cfg_q(cfg_q), .err_q(err_q)
  );

  cfg_window_decode #(.ADDR_W(ADDR_W)) u_dec (
    .clk(clk), .rst(rst), .cfg_q(cfg_q), .err_q(err_q),
    .win_valid(win_valid), .win_base(win_base),
    .win_low_mask(low_mask), .win_log2(win_log2)
  );

  cfg_window_match #(.ADDR_W(ADDR_W)) u_match (
    .clk(clk), .rst(rst), .win_valid(win_valid), .win_base(win_base),
    .win_low_mask(low_mask), .win_log2(win_log2), .lk_addr(lk_addr),
    .lk_hit(lk_hit), .lk_bdf(bdf)
  );

  assign rd_data = cfg_q;
  assign len_err = err_q;
  assign lk_bus  = bdf.bus;
  assign lk_dev  = bdf.dev;
  assign lk_fn   = bdf.fn;
  assign lk_reg  = bdf.rg;
endmodule

// File: tb/cfg_window_decoder_test.sv
`timescale 1ns/1ps
module cfg_window_decoder_test;
  localparam int AW = 40;

  logic          clk = 0;
  logic          rst = 1;
  logic          wr_en = 0;
  logic [7:0]    wr_be = '0;
  logic [63:0]   wr_data = '0;
  logic [63:0]   rd_data;
  logic          win_valid;
  logic [AW-1:0] win_base;
  logic [4:0]    win_log2;
  logic          len_err;
  logic [AW-1:0] lk_addr = '0;
  logic          lk_hit;
  logic [7:0]    lk_bus;
  logic [4:0]    lk_dev;
  logic [2:0]    lk_fn;
  logic [11:0]   lk_reg;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cfg_window_decoder #(.ADDR_W(AW)) uut (.*);

  typedef struct packed {
    logic          wr;
    logic [7:0]    be;
    logic [63:0]   data;
    logic [AW-1:0] addr;
    logic          hit;
    logic [7:0]    bus;
    logic [4:0]    dev;
    logic [2:0]    fn;
    logic [11:0]   rg;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 8'hFF, 64'h0000_0000_B000_0001, 40'h00_B012_3456, 1'b1, 8'h01, 5'd4,  3'd3, 12'h456}, // R3 R8 256M
    '{1'b0, 8'h00, 64'h0,                   40'h00_C000_0000, 1'b0, 8'h00, 5'd0,  3'd0, 12'h000}, // R7 above
    '{1'b0, 8'h00, 64'h0,                   40'h00_AFFF_FFFF, 1'b0, 8'h00, 5'd0,  3'd0, 12'h000}, // R7 below
    '{1'b1, 8'hFF, 64'h0000_0000_E000_0003, 40'h00_E7FF_FFFF, 1'b1, 8'h7F, 5'd31, 3'd7, 12'hFFF}, // R3 R8 128M top
    '{1'b0, 8'h00, 64'h0,                   40'h00_E800_0000, 1'b0, 8'h00, 5'd0,  3'd0, 12'h000}, // R7 past end
    '{1'b1, 8'hFF, 64'h0000_0004_1400_0005, 40'h04_17FF_F000, 1'b1, 8'h3F, 5'd31, 3'd7, 12'h000}, // R3 R8 64M
    '{1'b0, 8'h00, 64'h0,                   40'h04_1800_0000, 1'b0, 8'h00, 5'd0,  3'd0, 12'h000}, // R7 past end
    '{1'b1, 8'hFF, 64'h0000_0000_B7FF_FFF1, 40'h00_B000_0010, 1'b1, 8'h00, 5'd0,  3'd0, 12'h010}, // R5 low bits ignored
    '{1'b1, 8'hFF, 64'h0000_0000_B000_0000, 40'h00_B000_0000, 1'b0, 8'h00, 5'd0,  3'd0, 12'h000}, // R2 disabled
    '{1'b1, 8'hFF, 64'h0000_0000_B000_0001, 40'h10_B000_0000, 1'b0, 8'h00, 5'd0,  3'd0, 12'h000}, // R7 bit 36 set
    '{1'b1, 8'h01, 64'hFFFF_FFFF_FFFF_FF03, 40'h00_B7FF_FFFF, 1'b1, 8'h7F, 5'd31, 3'd7, 12'hFFF}, // R4 lane 0 only
    '{1'b1, 8'h08, 64'h0000_0000_4000_0000, 40'h00_4000_1000, 1'b1, 8'h00, 5'd0,  3'd1, 12'h000}, // R4 lane 3 only
    '{1'b1, 8'h00, 64'hFFFF_FFFF_FFFF_FFFF, 40'h00_4000_1000, 1'b1, 8'h00, 5'd0,  3'd1, 12'h000}  // R4 no lanes
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic write(input logic [7:0] be, input logic [63:0] data);
    @(negedge clk);
    wr_en = 1; wr_be = be; wr_data = data;
    @(negedge clk);
    wr_en = 0; wr_be = '0;
  endtask

  task automatic lookup(input string req, input logic [AW-1:0] a, input logic h,
                        input logic [7:0] b, input logic [4:0] d, input logic [2:0] f,
                        input logic [11:0] r);
    lk_addr = a;
    #1;
    check(req, {63'd0, lk_hit}, {63'd0, h});
    check(req, {35'd0, lk_bus, lk_dev, lk_fn, lk_reg}, {35'd0, b, d, f, r});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check("R1", rd_data, 64'h0000_0000_B000_0001);
    check("R1", {58'd0, win_valid, win_log2}, {58'd0, 1'b1, 5'd28});
    check("R1", {24'd0, win_base}, 64'h0000_0000_B000_0000);
    check("R1", {63'd0, len_err}, 64'd0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].wr) write(VEC[i].be, VEC[i].data);
      lookup("R7/R8 table", VEC[i].addr, VEC[i].hit, VEC[i].bus, VEC[i].dev, VEC[i].fn, VEC[i].rg);
    end
    // R4 readback after two partial writes and an empty one
    check("R4", rd_data, 64'h0000_0000_4000_0003);
    check("R3", {59'd0, win_log2}, 64'd27);
    check("R5", {24'd0, win_base}, 64'h0000_0000_4000_0000);

    // R6 reserved size code
    write(8'h01, 64'h07);
    check("R6", {62'd0, len_err, win_valid}, {62'd0, 1'b1, 1'b0});
    check("R6", {59'd0, win_log2}, 64'd0);
    check("R6", {24'd0, win_base}, 64'd0);
    lookup("R6", 40'h00_4000_1000, 1'b0, 8'h00, 5'd0, 3'd0, 12'h000);
    write(8'h02, 64'h0000_0000_0000_5500);
    check("R6 sticky", {63'd0, len_err}, 64'd1);
    write(8'h01, 64'h01);
    check("R6 clear", {62'd0, len_err, win_valid}, {62'd0, 1'b0, 1'b1});
    // base 0x4000_0000 from lanes kept, byte1 0x55 below bit 28 ignored (R5)
    lookup("R6 R5", 40'h00_4000_1000, 1'b1, 8'h00, 5'd0, 3'd1, 12'h000);

    // R9 same-cycle write and lookup: new window, old decode answers
    @(negedge clk);
    lk_addr = 40'h00_C010_0000;
    wr_en = 1; wr_be = 8'hFF; wr_data = 64'h0000_0000_C000_0001;
    #1;
    check("R9 before edge", {63'd0, lk_hit}, 64'd0);
    @(negedge clk);
    wr_en = 0; wr_be = '0;
    #1;
    check("R9 after edge", {55'd0, lk_hit, lk_bus}, {55'd0, 1'b1, 8'h01});

    // R9 reserved write while the lookup hits the old window
    @(negedge clk);
    wr_en = 1; wr_be = 8'h01; wr_data = 64'h07;
    #1;
    check("R9 R6 before edge", {63'd0, lk_hit}, 64'd1);
    @(negedge clk);
    wr_en = 0; wr_be = '0;
    #1;
    check("R9 R6 after edge", {62'd0, lk_hit, len_err}, {62'd0, 1'b0, 1'b1});

    // R1 reset mid-run clears error and restores default
    @(negedge clk);
    rst = 1;
    @(negedge clk);
    rst = 0;
    #1;
    check("R1 rerun", rd_data, 64'h0000_0000_B000_0001);
    check("R1 rerun", {63'd0, len_err}, 64'd0);
    lookup("R1 R8", 40'h00_BFFF_FFFF, 1'b1, 8'hFF, 5'd31, 3'd7, 12'hFFF);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule